// File: doc/BRIEF.md
# Sector and Block Erase Sequencer

This block sits behind the serial front end of a flash slave and handles the erase commands. While chip-select is low it shifts in a serial frame, most significant bit first: one opcode byte followed by a 24-bit address. When chip-select rises it decides whether the frame is a legal erase. If so, it runs a self-timed erase that walks a small region or a large region of the array and writes FFh into every byte through a simple memory write port. Busy stays high for the whole walk.

An erase needs three things: a prior write-enable, a frame of exactly 32 bits, and a target outside every protected block. The write-enable latch is set by a one-cycle pulse from elsewhere in the slave and is cleared at the moment an erase starts. While an erase is running, no further erase frame is accepted. The region sizes and the array size are parameters. The defaults are a 4 KByte sector, a 64 KByte block and a 256 KByte array.

Top module: `erase_seq`

## Requirements
- R1: Opcode 20h or D7h selects a sector erase of 2^SEC_W bytes (4 KByte by default). Its base is the address with bits SEC_W-1..0 cleared.
- R2: Opcode D8h selects a block erase of 2^BLK_W bytes (64 KByte by default). Its base is the address with bits BLK_W-1..0 cleared.
- R3: Address bits at or above ADDR_W are ignored, and so are the bits below the selected region size.
- R4: An accepted erase raises busy_o in the first cycle after chip-select rises. It then writes FFh once to each byte of the region, one byte per cycle in ascending order from the base. busy_o stays high for exactly as many cycles as the region has bytes. No byte outside the region is written.
- R5: The frame is sampled on clock edges where bit_valid_i is high and cs_n_i is low. The first 8 bits are the opcode and the next 24 bits are the address, MSB first. An erase is considered only if exactly 32 bits arrived before chip-select rose; 31 or 33 bits abort the command.
- R6: An erase runs only if the write-enable latch (wel_o) is set. A wel_set_i pulse sets the latch, and it stays set across aborted or ignored commands.
- R7: Bit k of prot_i protects block k, where k is address bits ADDR_W-1..BLK_W. A sector or block erase that targets a protected block is ignored.
- R8: While busy_o is high, every new erase frame is ignored. A wel_set_i pulse still sets the latch during this time.
- R9: The write-enable latch is cleared in the same cycle that busy_o rises.
- R10: Any other opcode is ignored.
- R11: After reset, busy_o, mem_we_o and wel_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select, active low |
| bit_valid_i | input | 1 | A serial bit is present on bit_i |
| bit_i | input | 1 | Serial command bit |
| wel_set_i | input | 1 | One-cycle pulse that sets the write-enable latch |
| prot_i | input | NBLK | Per-block protection |
| busy_o | output | 1 | Erase in progress |
| wel_o | output | 1 | Write-enable latch |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | 8 | Memory write data (FFh) |

## Verification
The bench keeps its own image of the array and compares every byte after each command, so it also catches a region that is misaligned or sized wrongly. A design that ignored the upper address bits badly, or took the base from the wrong bits, would erase the wrong bytes. Frames one bit short or one bit long are sent to catch a counter that checks only for at least 32 bits. A command sent without write-enable right after a successful erase exposes a latch that is never cleared. A command sent with write-enable mid-erase exposes a sequencer that restarts or merges a second region.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam logic [7:0] OP_SECT_A = 8'h20;
  localparam logic [7:0] OP_SECT_B = 8'hD7;
  localparam logic [7:0] OP_BLOCK  = 8'hD8;
  localparam int unsigned FRAME_BITS = 32;

  typedef enum logic [1:0] {
    ER_NONE  = 2'd0,
    ER_SECT  = 2'd1,
    ER_BLOCK = 2'd2
  } er_kind_e;
endpackage

// File: rtl/erase_rx.sv
module erase_rx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_n_i,
  input  logic        bit_valid_i,
  input  logic        bit_i,
  output logic [31:0] frame_o,
  output logic        len_ok_o,
  output logic        cs_rise_o
);
  import erase_pkg::*;

  logic [31:0] sr_q;
  logic [5:0]  cnt_q;
  logic        cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
    end else begin
      cs_n_q <= cs_n_i;
      if (cs_n_i) begin
        cnt_q <= '0;
      end else if (bit_valid_i) begin
        sr_q <= {sr_q[30:0], bit_i};
        if (cnt_q != 6'd63) cnt_q <= cnt_q + 6'd1;
      end
    end
  end

  assign frame_o   = sr_q;
  assign len_ok_o  = (cnt_q == 6'(FRAME_BITS));
  assign cs_rise_o = cs_n_i && !cs_n_q;

  // R5
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_n_i) |-> cnt_q == '0);
endmodule

// File: rtl/erase_decode.sv
module erase_decode #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned NBLK   = 1 << (ADDR_W - BLK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       frame_i,
  input  logic              len_ok_i,
  input  logic              cs_rise_i,
  input  logic              wel_set_i,
  input  logic [NBLK-1:0]   prot_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              blk_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              wel_o
);
  import erase_pkg::*;

  localparam int unsigned NB_W = ADDR_W - BLK_W;
  localparam logic [ADDR_W-1:0] SEC_MASK = ~ADDR_W'((1 << SEC_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'((1 << BLK_W) - 1);

  logic [7:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [NB_W-1:0]   blk_idx;
  er_kind_e          kind;
  logic              wel_q;

  assign op      = frame_i[31:24];
  assign addr    = frame_i[ADDR_W-1:0];
  assign blk_idx = addr[ADDR_W-1:BLK_W];

  always_comb begin
    unique case (op)
      OP_SECT_A, OP_SECT_B: kind = ER_SECT;
      OP_BLOCK:             kind = ER_BLOCK;
      default:              kind = ER_NONE;
    endcase
  end

  assign start_o = cs_rise_i && len_ok_i && (kind != ER_NONE) &&
                   wel_q && !prot_i[blk_idx] && !busy_i;
  assign blk_o   = (kind == ER_BLOCK);
  assign base_o  = addr & (blk_o ? BLK_MASK : SEC_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wel_q <= 1'b0;
    else if (start_o)   wel_q <= 1'b0;
    else if (wel_set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R9
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !wel_q);
endmodule

// File: rtl/erase_engine.sv
module erase_engine #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12,
  parameter int unsigned BLK_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              blk_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [BLK_W-1:0] BLK_LAST = '1;
  localparam logic [BLK_W-1:0] SEC_LAST = BLK_W'((1 << SEC_W) - 1);

  logic              busy_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BLK_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ptr_q  <= base_i;
      left_q <= blk_i ? BLK_LAST : SEC_LAST;
    end else if (busy_q) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        ptr_q  <= ptr_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign addr_o = ptr_q;

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> ptr_q == $past(ptr_q) + 1'b1);
  // R4
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(left_q) == '0);
endmodule

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned NBLK   = 1 << (ADDR_W - BLK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              wel_set_i,
  input  logic [NBLK-1:0]   prot_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  logic [31:0]       frame;
  logic              len_ok, cs_rise, start, blk;
  logic [ADDR_W-1:0] base;

  erase_rx u_rx (
    .clk_i, .rst_ni, .cs_n_i, .bit_valid_i, .bit_i,
    .frame_o(frame), .len_ok_o(len_ok), .cs_rise_o(cs_rise)
  );

  erase_decode #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W), .NBLK(NBLK)) u_dec (
    .clk_i, .rst_ni, .frame_i(frame), .len_ok_i(len_ok), .cs_rise_i(cs_rise),
    .wel_set_i, .prot_i, .busy_i(busy_o), .start_o(start), .blk_o(blk),
    .base_o(base), .wel_o
  );

  erase_engine #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .blk_i(blk), .base_i(base),
    .busy_o, .addr_o(mem_addr_o)
  );

  assign mem_we_o   = busy_o;
  assign mem_data_o = 8'hFF;

  // R4 R5
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise) && $past(len_ok));
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> mem_addr_o != $past(mem_addr_o));
endmodule

// File: tb/erase_seq_bench.sv
module erase_seq_bench;
  localparam int AW = 10, SW = 5, BW = 8, NB = 4;
  localparam int MEMN = 1 << AW;

  logic clk = 0, rst_n = 0, cs_n = 1, bv = 0, bi = 0, wset = 0;
  logic [NB-1:0] prot = 4'b1000;
  logic busy, wel, we;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;
  int checks = 0, fails = 0, we_cnt = 0;
  logic [7:0] mem [MEMN];
  logic [7:0] exp_mem [MEMN];
  logic wel_m = 0;

  always #4 clk = ~clk;

  erase_seq #(.ADDR_W(AW), .SEC_W(SW), .BLK_W(BW), .NBLK(NB)) u_erase_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .bit_valid_i(bv), .bit_i(bi),
    .wel_set_i(wset), .prot_i(prot), .busy_o(busy), .wel_o(wel),
    .mem_we_o(we), .mem_addr_o(waddr), .mem_data_o(wdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= {1'b0, 7'(i)};
    end else if (we) begin
      mem[waddr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [5:0]  nbits;
    logic        wren;
    logic [9:0]  base;
    logic [8:0]  len;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{8'h20, 24'h000123, 6'd32, 1'b1, 10'h120, 9'd32},   // R1
    '{8'hD7, 24'h0002FF, 6'd32, 1'b1, 10'h2E0, 9'd32},   // R1
    '{8'h20, 24'h000050, 6'd32, 1'b0, 10'h000, 9'd0},    // R6 R9
    '{8'hD8, 24'h0001AB, 6'd32, 1'b1, 10'h100, 9'd256},  // R2
    '{8'h20, 24'hFFF047, 6'd32, 1'b1, 10'h040, 9'd32},   // R3
    '{8'hD8, 24'h000310, 6'd32, 1'b1, 10'h000, 9'd0},    // R7
    '{8'h20, 24'h0003C5, 6'd32, 1'b1, 10'h000, 9'd0},    // R7
    '{8'h03, 24'h000000, 6'd32, 1'b1, 10'h000, 9'd0},    // R10
    '{8'h20, 24'h000080, 6'd31, 1'b1, 10'h000, 9'd0},    // R5
    '{8'h20, 24'h000080, 6'd33, 1'b1, 10'h000, 9'd0},    // R5
    '{8'h20, 24'h000080, 6'd32, 1'b0, 10'h080, 9'd32}    // R6
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pulse_wel();
    @(negedge clk); wset = 1;
    @(negedge clk); wset = 0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a, input int nb);
    logic [39:0] w;
    w = {8'h00, op, a};
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); cs_n = 0; bv = 1; bi = w[i];
    end
    @(negedge clk); bv = 0; cs_n = 1;
  endtask

  task automatic cmp_mem(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < MEMN; i++) exp_mem[i] = {1'b0, 7'(i)};
    repeat (3) @(negedge clk);
    // R11
    chk(busy == 0 && we == 0 && wel == 0, "R11 reset outputs", {busy, we, wel}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 11; v++) begin
      int c0;
      if (VEC[v].wren) begin pulse_wel(); wel_m = 1; end
      c0 = we_cnt;
      send_cmd(VEC[v].op, VEC[v].addr, int'(VEC[v].nbits));
      repeat (300) @(negedge clk);
      if (VEC[v].len != 0) begin
        for (int i = 0; i < int'(VEC[v].len); i++) exp_mem[int'(VEC[v].base) + i] = 8'hFF;
        wel_m = 0;
      end
      chk(we_cnt - c0 == int'(VEC[v].len), "R4 write count", we_cnt - c0, int'(VEC[v].len));
      cmp_mem("R4 array contents");
      chk(wel == wel_m, "R9 R6 write-enable latch", wel, wel_m);
    end

    // R8: frame during busy is ignored, latch still sets
    begin
      int c0;
      pulse_wel();
      c0 = we_cnt;
      send_cmd(8'hD8, 24'h000000, 32);
      @(negedge clk);
      chk(busy == 1 && waddr == 0, "R4 busy start cycle", {busy, waddr}, {1'b1, 10'h000});
      chk(wel == 0, "R9 latch cleared at start", wel, 0);
      pulse_wel();
      send_cmd(8'h20, 24'h000200, 32);
      chk(busy == 1, "R8 still busy", busy, 1);
      repeat (300) @(negedge clk);
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      chk(we_cnt - c0 == 256, "R8 single region written", we_cnt - c0, 256);
      cmp_mem("R8 array contents");
      chk(wel == 1, "R8 latch set during busy", wel, 1);
      chk(busy == 0, "R4 busy released", busy, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule